// File: doc/BRIEF.md
# ALU Status Flag Generator

This block turns the outcome of an 8-bit or 16-bit arithmetic or logic operation into condition flags. It holds them, with three control flags, in one 16-bit status word. The ALU datapath sits beside it and presents five inputs:

- both operands,
- the raw result,
- the carry or borrow out of the selected width,
- an operation class,
- a size select.

A one-cycle update strobe commits the new condition flags. The trap, interrupt-enable and direction flags each have their own set and clear inputs. They can change in any cycle, including one in which the condition flags also update.

The status word is a register. A value latched at a rising edge appears on `flags_o` straight after that edge. Byte operations use only bits 7:0 of the result for zero and sign. Parity always looks at bits 7:0, whatever the size. The auxiliary flag tracks the carry or borrow across the nibble boundary (from bit 3 into bit 4).

Top module: `flag_unit`

## Requirements
- R1: Synchronous active-high `rst` clears the whole status word to 16'h0000 at the next rising edge.
- R2: Carry sits at bit 0. With the update strobe high, class 0 (add) loads it from `cy_i`, class 1 (subtract) loads it from `cy_i` taken as the borrow, and classes 2 and 3 (logic) clear it.
- R3: Parity sits at bit 2. It becomes 1 when `res_i[7:0]` holds an even number of ones and 0 when the count is odd, for either size.
- R4: Auxiliary sits at bit 4. For add and subtract it becomes the carry or borrow from bit 3 into bit 4; a logic class leaves it unchanged.
- R5: Zero sits at bit 6. It becomes 1 exactly when the result over the selected size (bits 7:0 when `wide_i`=0, bits 15:0 when `wide_i`=1) is zero.
- R6: Sign sits at bit 7. It takes the most significant bit of the selected size: bit 7 for bytes, bit 15 for words.
- R7: Overflow sits at bit 11. For add it is set when both operands have the same sign and the result sign differs from it. For subtract it is set when the operand signs differ and the result sign differs from the minuend's. Logic clears it.
- R8: While `upd_i` is low, bits 0, 2, 4, 6, 7 and 11 keep their values.
- R9: Trap (bit 8), interrupt enable (bit 9, 1 = enabled) and direction (bit 10, 1 = step downward) each go to 1 on their set input and to 0 on their clear input. Clear wins when both are high. With neither input high the flag holds, whatever `upd_i` does.
- R10: Bits 1, 3, 5, 12, 13, 14 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | 16 | First operand (minuend for subtract) |
| opb_i | input | 16 | Second operand (subtrahend for subtract) |
| res_i | input | 16 | Raw ALU result |
| cy_i | input | 1 | Carry-out or borrow of the selected size |
| opc_i | input | 2 | Operation class: 0 add, 1 subtract, 2/3 logic |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| upd_i | input | 1 | Condition flag update strobe |
| trp_set_i | input | 1 | Set trap flag |
| trp_clr_i | input | 1 | Clear trap flag |
| ien_set_i | input | 1 | Set interrupt-enable flag |
| ien_clr_i | input | 1 | Clear interrupt-enable flag |
| dir_set_i | input | 1 | Set direction flag |
| dir_clr_i | input | 1 | Clear direction flag |
| flags_o | output | 16 | Status word |

## Verification
A condition flag update and a control flag set or clear can land in the same clock cycle and write different fields of the same word. The random stimulus raises each control set and clear input on its own, largely independent of the update strobe. Many cycles therefore carry an update together with one or more control writes, sometimes with set and clear on the same flag. After each edge, every field is compared against a bench model that handles the two paths separately. A write through either path that spills into the other's bits shows up as a mismatch on a named field.

// File: rtl/flag_pkg.sv
package flag_pkg;

  localparam int FLAG_W = 16;

  // bit positions inside the status word
  localparam int POS_CY  = 0;
  localparam int POS_PAR = 2;
  localparam int POS_AUX = 4;
  localparam int POS_ZF  = 6;
  localparam int POS_SG  = 7;
  localparam int POS_TRP = 8;
  localparam int POS_IEN = 9;
  localparam int POS_DIR = 10;
  localparam int POS_OVF = 11;

  localparam int NCTL = 3;

  localparam logic [FLAG_W-1:0] COND_MASK =
    (FLAG_W'(1) << POS_CY) | (FLAG_W'(1) << POS_PAR) | (FLAG_W'(1) << POS_AUX) |
    (FLAG_W'(1) << POS_ZF) | (FLAG_W'(1) << POS_SG)  | (FLAG_W'(1) << POS_OVF);
  localparam logic [FLAG_W-1:0] CTRL_MASK =
    (FLAG_W'(1) << POS_TRP) | (FLAG_W'(1) << POS_IEN) | (FLAG_W'(1) << POS_DIR);

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_RSVD  = 2'd3
  } opc_e;

  typedef struct packed {
    logic ovf;
    logic sg;
    logic zf;
    logic aux;
    logic par;
    logic cy;
  } cond_t;

endpackage

// File: rtl/flag_cond.sv
module flag_cond
  import flag_pkg::*;
#(
  parameter int DW  = 16,
  parameter int BW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic          cy_i,
  input  logic [1:0]    opc_i,
  input  logic          wide_i,
  input  logic          aux_prev_i,
  output cond_t         nxt_o
);

  logic sa, sb, sr;
  logic is_arith, is_sub;
  logic nib_cross;

  always_comb begin
    sa = wide_i ? opa_i[DW-1] : opa_i[BW-1];
    sb = wide_i ? opb_i[DW-1] : opb_i[BW-1];
    sr = wide_i ? res_i[DW-1] : res_i[BW-1];
  end

  assign is_sub   = (opc_i == OPC_SUB);
  assign is_arith = (opc_i == OPC_ADD) || is_sub;
  // carry or borrow into bit NIB is recovered from the sum bit
  assign nib_cross = opa_i[NIB] ^ opb_i[NIB] ^ res_i[NIB];

  always_comb begin
    nxt_o.cy  = is_arith & cy_i;
    nxt_o.par = ~^res_i[BW-1:0];
    nxt_o.aux = is_arith ? nib_cross : aux_prev_i;
    nxt_o.zf  = wide_i ? (res_i == '0) : (res_i[BW-1:0] == '0);
    nxt_o.sg  = sr;
    if (!is_arith)
      nxt_o.ovf = 1'b0;
    else if (is_sub)
      nxt_o.ovf = (sa != sb) && (sr != sa);
    else
      nxt_o.ovf = (sa == sb) && (sr != sa);
  end

endmodule

// File: rtl/flag_ctl_bit.sv
module flag_ctl_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst)
      q_o <= 1'b0;
    else if (clr_i)
      q_o <= 1'b0;
    else if (set_i)
      q_o <= 1'b1;
  end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  input  logic [DW-1:0]     res_i,
  input  logic              cy_i,
  input  logic [1:0]        opc_i,
  input  logic              wide_i,
  input  logic              upd_i,
  input  logic              trp_set_i,
  input  logic              trp_clr_i,
  input  logic              ien_set_i,
  input  logic              ien_clr_i,
  input  logic              dir_set_i,
  input  logic              dir_clr_i,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int NIB = BW / 2;

  cond_t cond_d, cond_q;
  logic [NCTL-1:0] ctl_set, ctl_clr, ctl_q;

  flag_cond #(.DW(DW), .BW(BW), .NIB(NIB)) u_cond (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .res_i      (res_i),
    .cy_i       (cy_i),
    .opc_i      (opc_i),
    .wide_i     (wide_i),
    .aux_prev_i (cond_q.aux),
    .nxt_o      (cond_d)
  );

  always_ff @(posedge clk) begin
    if (rst)
      cond_q <= '0;
    else if (upd_i)
      cond_q <= cond_d;
  end

  // index 0 trap, 1 interrupt enable, 2 direction
  assign ctl_set = {dir_set_i, ien_set_i, trp_set_i};
  assign ctl_clr = {dir_clr_i, ien_clr_i, trp_clr_i};

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    flag_ctl_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (ctl_set[i]),
      .clr_i (ctl_clr[i]),
      .q_o   (ctl_q[i])
    );
  end

  always_comb begin
    flags_o          = '0;
    flags_o[POS_CY]  = cond_q.cy;
    flags_o[POS_PAR] = cond_q.par;
    flags_o[POS_AUX] = cond_q.aux;
    flags_o[POS_ZF]  = cond_q.zf;
    flags_o[POS_SG]  = cond_q.sg;
    flags_o[POS_OVF] = cond_q.ovf;
    flags_o[POS_TRP] = ctl_q[0];
    flags_o[POS_IEN] = ctl_q[1];
    flags_o[POS_DIR] = ctl_q[2];
  end

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DW-1:0]     res_i,
  input logic [1:0]        opc_i,
  input logic              upd_i,
  input logic              trp_set_i,
  input logic              trp_clr_i,
  input logic              ien_set_i,
  input logic              ien_clr_i,
  input logic              dir_set_i,
  input logic              dir_clr_i,
  input logic [FLAG_W-1:0] flags_o
);

  logic ctl_quiet;
  logic is_logic;
  assign ctl_quiet = !(trp_set_i | trp_clr_i | ien_set_i | ien_clr_i | dir_set_i | dir_clr_i);
  assign is_logic  = opc_i[1];

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> flags_o == '0); // R1
  AST_LOGIC_NO_CY: assert property (@(posedge clk) disable iff (rst) (upd_i && is_logic) |=> !flags_o[POS_CY]); // R2
  AST_PARITY_LOW: assert property (@(posedge clk) disable iff (rst) upd_i |=> flags_o[POS_PAR] == ~^$past(res_i[BW-1:0])); // R3
  AST_AUX_KEEP: assert property (@(posedge clk) disable iff (rst) (upd_i && is_logic) |=> $stable(flags_o[POS_AUX])); // R4
  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst) (upd_i && is_logic) |=> !flags_o[POS_OVF]); // R7
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst) !upd_i |=> $stable(flags_o & COND_MASK)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) ctl_quiet |=> $stable(flags_o & CTRL_MASK)); // R9
  AST_DIR_CLR_WINS: assert property (@(posedge clk) disable iff (rst) dir_clr_i |=> !flags_o[POS_DIR]); // R9
  AST_IEN_SET: assert property (@(posedge clk) disable iff (rst) (ien_set_i && !ien_clr_i) |=> flags_o[POS_IEN]); // R9

  always_comb begin
    AST_UNUSED_ZERO: assert ((flags_o & ~(COND_MASK | CTRL_MASK)) == '0); // R10
  end

endmodule

bind flag_unit flag_unit_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_i     (res_i),
  .opc_i     (opc_i),
  .upd_i     (upd_i),
  .trp_set_i (trp_set_i),
  .trp_clr_i (trp_clr_i),
  .ien_set_i (ien_set_i),
  .ien_clr_i (ien_clr_i),
  .dir_set_i (dir_set_i),
  .dir_clr_i (dir_clr_i),
  .flags_o   (flags_o)
);

// File: tb/flag_unit_bench.sv
module flag_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] opa, opb, res;
  logic        cy;
  logic [1:0]  opc;
  logic        wide, upd;
  logic        trp_s, trp_c, ien_s, ien_c, dir_s, dir_c;
  logic [15:0] flags;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_unit u_flag_unit (
    .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .res_i(res), .cy_i(cy),
    .opc_i(opc), .wide_i(wide), .upd_i(upd),
    .trp_set_i(trp_s), .trp_clr_i(trp_c), .ien_set_i(ien_s), .ien_clr_i(ien_c),
    .dir_set_i(dir_s), .dir_clr_i(dir_c), .flags_o(flags)
  );

  function automatic int sval(input logic [15:0] v, input logic w);
    if (w) return int'($signed(v));
    return int'($signed(v[7:0]));
  endfunction

  // expected next status word from the requirements
  function automatic logic [15:0] model_next(input logic [15:0] cur);
    logic [15:0] n;
    int s;
    logic arith;
    n = cur;
    arith = (opc == 2'd0) || (opc == 2'd1);
    if (upd) begin
      n[0] = arith ? cy : 1'b0;
      n[2] = (^res[7:0]) == 1'b0;
      if (opc == 2'd0) n[4] = (opa[3:0] + opb[3:0]) > 5'd15;
      else if (opc == 2'd1) n[4] = opa[3:0] < opb[3:0];
      n[6] = wide ? (res == 16'h0) : (res[7:0] == 8'h0);
      n[7] = wide ? res[15] : res[7];
      if (opc == 2'd0) s = sval(opa, wide) + sval(opb, wide);
      else s = sval(opa, wide) - sval(opb, wide);
      if (!arith) n[11] = 1'b0;
      else if (wide) n[11] = (s > 32767) || (s < -32768);
      else n[11] = (s > 127) || (s < -128);
    end
    if (trp_c) n[8] = 1'b0; else if (trp_s) n[8] = 1'b1;
    if (ien_c) n[9] = 1'b0; else if (ien_s) n[9] = 1'b1;
    if (dir_c) n[10] = 1'b0; else if (dir_s) n[10] = 1'b1;
    return n;
  endfunction

  task automatic cmp(input string tag, input logic [15:0] mask);
    n_cmp++;
    if ((flags & mask) !== (exp_w & mask)) begin
      n_bad++;
      $display("FAIL %s: flags&%h actual %h expected %h", tag, mask, flags & mask, exp_w & mask);
    end
  endtask

  task automatic check_all(input logic was_upd);
    if (was_upd) begin
      cmp("R2 carry", 16'h0001);
      cmp("R3 parity", 16'h0004);
      cmp("R4 aux", 16'h0010);
      cmp("R5 zero", 16'h0040);
      cmp("R6 sign", 16'h0080);
      cmp("R7 overflow", 16'h0800);
    end else begin
      cmp("R8 hold", 16'h08D5);
    end
    cmp("R9 control", 16'h0700);
    cmp("R10 unused", 16'hF02A);
  endtask

  // drive one operation: result and carry computed from operands and class
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [1:0] oc,
                       input logic w, input logic u, input logic [5:0] ctl, input logic [1:0] lsel);
    logic [16:0] t;
    logic        was_u;
    @(negedge clk);
    opa = a; opb = b; opc = oc; wide = w; upd = u;
    {dir_c, dir_s, ien_c, ien_s, trp_c, trp_s} = ctl;
    if (oc == 2'd0) begin
      t = w ? ({1'b0, a} + {1'b0, b}) : {8'h0, {1'b0, a[7:0]} + {1'b0, b[7:0]}};
      cy = w ? t[16] : t[8];
    end else if (oc == 2'd1) begin
      t = w ? ({1'b0, a} - {1'b0, b}) : {8'h0, {1'b0, a[7:0]} - {1'b0, b[7:0]}};
      cy = w ? (a < b) : (a[7:0] < b[7:0]);
    end else begin
      case (lsel)
        2'd0: t = {1'b0, a & b};
        2'd1: t = {1'b0, a | b};
        default: t = {1'b0, a ^ b};
      endcase
      cy = $urandom_range(0, 1) == 1;
    end
    // byte ops: upper result byte carries junk that must not matter
    res = w ? t[15:0] : {a[15:8] ^ 8'h5A, t[7:0]};
    exp_w = model_next(exp_w);
    was_u = u;
    @(negedge clk);
    check_all(was_u);
    upd = 1'b0;
    {dir_c, dir_s, ien_c, ien_s, trp_c, trp_s} = 6'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; opa = '0; opb = '0; res = '0; cy = 1'b0; opc = 2'd0;
    wide = 1'b0; upd = 1'b0;
    {dir_c, dir_s, ien_c, ien_s, trp_c, trp_s} = 6'b0;
    exp_w = 16'h0;
    repeat (3) @(negedge clk);
    cmp("R1 reset", 16'hFFFF);
    rst = 1'b0;

    // directed corners
    apply(16'h007F, 16'h0001, 2'd0, 1'b0, 1'b1, 6'b0, 2'd0);      // byte ovf, aux, sign
    apply(16'hFFFF, 16'h0001, 2'd0, 1'b1, 1'b1, 6'b0, 2'd0);      // word zero, carry
    apply(16'h1280, 16'h0001, 2'd1, 1'b0, 1'b1, 6'b0, 2'd0);      // byte sub ovf, borrow nib
    apply(16'h0000, 16'h0001, 2'd1, 1'b1, 1'b1, 6'b0, 2'd0);      // word borrow
    apply(16'h000F, 16'h0001, 2'd0, 1'b0, 1'b1, 6'b0, 2'd0);      // aux set before logic
    apply(16'hF0F0, 16'h0F0F, 2'd2, 1'b1, 1'b1, 6'b0, 2'd1);      // logic: aux kept
    apply(16'h8000, 16'h8000, 2'd0, 1'b1, 1'b0, 6'b010101, 2'd0); // no update, sets only
    apply(16'h0001, 16'h0001, 2'd0, 1'b1, 1'b1, 6'b111111, 2'd0); // clear wins, same cycle as update
    apply(16'h0300, 16'h0300, 2'd2, 1'b0, 1'b1, 6'b0, 2'd2);      // byte zero, word nonzero
    apply(16'h8000, 16'h0001, 2'd1, 1'b1, 1'b1, 6'b000100, 2'd0); // word sub ovf

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ctl;
      for (int k = 0; k < 6; k++) ctl[k] = ($urandom_range(0, 3) == 0);
      apply(16'($urandom), 16'($urandom), 2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
            $urandom_range(0, 3) != 0, ctl, 2'($urandom_range(0, 2)));
    end

    // reset mid-run
    @(negedge clk); rst = 1'b1; exp_w = 16'h0;
    @(negedge clk); cmp("R1 reset", 16'hFFFF); rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule